// File: doc/BRIEF.md
# Queued SPI Transfer Sequencer

This block runs a list of SPI word transfers on its own, with no processor action per word. Software fills a 16-slot command queue through a small register port. Each slot holds a transmit word, the number of bits to send, the chip-select line to drive, and a pause measured in clock cycles to insert after the word. Software then picks a first and a last slot and sets a run bit. The sequencer walks the slots in ascending order, with the index wrapping from 15 to 0. It drives one transfer per slot and stores the word shifted in from the peripheral into a receive slot that has the same index as the command.

When the last slot is done in one-shot mode, the sequencer clears the run bit and sets a sticky completion flag. In continuous mode it goes back to the first slot and keeps going, so the receive slots always hold fresh readings of the peripherals. Software reads them like ordinary registers. Clearing the run bit stops the sequencer at a word boundary. The serial side works in clock mode 0: the clock idles low, the peripheral samples on the rising edge, and the controller moves to the next bit on the falling edge. Bits leave most significant first.

Top module: `spiq_ctrl`

## Requirements
- R1: After reset, all four chip-select outputs are high, the serial clock is low, the completion flag reads 0 and the control register reads 0.
- R2: A command word written at address i (0..15) holds the transmit word in bits [15:0], the bit count minus one in bits [19:16], the chip-select number in bits [21:20] and the post-transfer pause in bits [29:22]. The transfer shifts out the low (count) bits of the transmit word, most significant of those first.
- R3: The serial clock stays low whenever no chip select is asserted. Each bit gives exactly one rising clock edge, and data is valid on that edge.
- R4: At most one chip-select output is low at a time. It is the one numbered in the command, and the pattern only changes from or to all-high.
- R5: The received bits, right-aligned and zero-extended, can be read at address 16+i, where i is the index of the command that produced them.
- R6: Writing control address 32 with bit0 = run, bit1 = continuous, bits[7:4] = first slot and bits[11:8] = last slot starts the transfers. They run from the first slot to the last slot in ascending order with no further writes.
- R7: Between two transfers of one run, all chip selects stay high for exactly the pause of the earlier command plus 4 clock cycles.
- R8: In one-shot mode, after the last slot the run bit reads 0 and status bit0 at address 33 reads 1. The flag stays 1 until a write of 1 to status bit0 clears it.
- R9: In continuous mode the sequencer goes back to the first slot after the last slot, with no gap other than the normal pause.
- R10: Clearing the run bit while a word is in flight lets that word finish with its full bit count. No further transfer starts, and the completion flag is not set.
- R11: When the last slot index is below the first, the walk passes from slot 15 to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 32 | Read data, valid one cycle after rd_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to peripheral |
| miso | input | 1 | Serial data from peripheral |
| cs_n | output | 4 | Active-low chip selects |

## Verification
A table of six commands runs in one-shot mode. It mixes bit counts of 16, 12, 8, 5 and 1, uses every chip-select line, and has pauses from 0 to 7. This separates errors in length alignment, bit order, select decoding and pause counting. The peripheral model answers each word with a different pattern, so any receive slot written at the wrong index shows up when read back. A second run in continuous mode over slots 14, 15 and 0 tests wrap-around of both the walk and the index. The run bit is cleared in the middle of a word, which shows whether the sequencer finishes that word and then stops.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  localparam int DATA_W   = 16;
  localparam int NUM_CS   = 4;
  localparam int DEPTH    = 16;
  localparam int DLY_W    = 8;
  localparam int HALF_DIV = 2;
  localparam int BUS_W    = 32;

  typedef enum logic [2:0] {SQ_IDLE, SQ_FETCH, SQ_ISSUE, SQ_BUSY, SQ_GAP} seq_state_t;
  typedef enum logic [1:0] {EN_IDLE, EN_LOW, EN_HIGH, EN_TAIL} eng_state_t;
endpackage

// File: rtl/spiq_engine.sv
module spiq_engine import spiq_pkg::*; #(
  parameter int DW  = DATA_W,
  parameter int NCS = NUM_CS,
  parameter int DIV = HALF_DIV
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [DW-1:0]          tx,
  input  logic [$clog2(DW)-1:0]  len_m1,
  input  logic [$clog2(NCS)-1:0] cs_sel,
  input  logic                   miso,
  output logic                   sclk,
  output logic                   mosi,
  output logic [NCS-1:0]         cs_n,
  output logic                   done,
  output logic [DW-1:0]          rx
);
  localparam int LEN_W = $clog2(DW);
  localparam int DIV_W = $clog2(DIV + 1);

  eng_state_t       st;
  logic [DIV_W-1:0] div;
  logic [LEN_W-1:0] bits_left;
  logic [DW-1:0]    sh;
  logic [DW-1:0]    aligned;
  logic             tick;

  assign tick = (div == DIV_W'(DIV - 1));

  always_comb begin
    aligned = tx << (LEN_W'(DW - 1) - len_m1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= EN_IDLE;
      div       <= '0;
      bits_left <= '0;
      sh        <= '0;
      rx        <= '0;
      sclk      <= 1'b0;
      mosi      <= 1'b0;
      cs_n      <= '1;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == EN_IDLE) div <= '0;
      else               div <= tick ? '0 : div + 1'b1;
      case (st)
        EN_IDLE: if (start) begin
          cs_n      <= ~(NCS'(1) << cs_sel);
          sh        <= aligned;
          mosi      <= aligned[DW-1];
          bits_left <= len_m1;
          rx        <= '0;
          st        <= EN_LOW;
        end
        EN_LOW: if (tick) begin
          sclk <= 1'b1;
          rx   <= {rx[DW-2:0], miso};
          st   <= EN_HIGH;
        end
        EN_HIGH: if (tick) begin
          sclk <= 1'b0;
          if (bits_left == '0) begin
            st <= EN_TAIL;
          end else begin
            sh        <= sh << 1;
            mosi      <= sh[DW-2];
            bits_left <= bits_left - 1'b1;
            st        <= EN_LOW;
          end
        end
        EN_TAIL: if (tick) begin
          cs_n <= '1;
          done <= 1'b1;
          st   <= EN_IDLE;
        end
        default: st <= EN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spiq_seq.sv
module spiq_seq import spiq_pkg::*; #(
  parameter int DEPTH_P = DEPTH,
  parameter int DLY_P   = DLY_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       run,
  input  logic                       wrap,
  input  logic [$clog2(DEPTH_P)-1:0] start_ptr,
  input  logic [$clog2(DEPTH_P)-1:0] end_ptr,
  input  logic [DLY_P-1:0]           dly,
  input  logic                       eng_done,
  output logic [$clog2(DEPTH_P)-1:0] idx,
  output logic                       eng_start,
  output logic                       rx_we,
  output logic                       finish
);
  seq_state_t       st;
  logic [DLY_P-1:0] gap;
  logic             decide;

  assign decide    = (st == SQ_GAP) && (gap == '0);
  assign eng_start = (st == SQ_ISSUE);
  assign rx_we     = (st == SQ_BUSY) && eng_done;
  assign finish    = decide && run && (idx == end_ptr) && !wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= SQ_IDLE;
      idx <= '0;
      gap <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (run) begin
          idx <= start_ptr;
          st  <= SQ_FETCH;
        end
        SQ_FETCH: st <= SQ_ISSUE;
        SQ_ISSUE: st <= SQ_BUSY;
        SQ_BUSY: if (eng_done) begin
          gap <= dly;
          st  <= SQ_GAP;
        end
        SQ_GAP: begin
          if (gap != '0) begin
            gap <= gap - 1'b1;
          end else if (!run) begin
            st <= SQ_IDLE;
          end else if (idx == end_ptr) begin
            if (wrap) begin
              idx <= start_ptr;
              st  <= SQ_FETCH;
            end else begin
              st <= SQ_IDLE;
            end
          end else begin
            idx <= idx + 1'b1;
            st  <= SQ_FETCH;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spiq_regs.sv
module spiq_regs import spiq_pkg::*; #(
  parameter int DW      = DATA_W,
  parameter int DEPTH_P = DEPTH,
  parameter int BW      = BUS_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [$clog2(DEPTH_P)+1:0] wr_addr,
  input  logic [BW-1:0]              wr_data,
  input  logic [$clog2(DEPTH_P)+1:0] rd_addr,
  output logic [BW-1:0]              rd_data,
  input  logic [$clog2(DEPTH_P)-1:0] cmd_raddr,
  output logic [BW-1:0]              cmd_q,
  input  logic                       rx_we,
  input  logic [$clog2(DEPTH_P)-1:0] rx_waddr,
  input  logic [DW-1:0]              rx_wdata,
  input  logic                       finish,
  output logic                       run,
  output logic                       wrap,
  output logic [$clog2(DEPTH_P)-1:0] start_ptr,
  output logic [$clog2(DEPTH_P)-1:0] end_ptr,
  output logic                       done_flag
);
  localparam int IDX_W  = $clog2(DEPTH_P);
  localparam int ADDR_W = IDX_W + 2;
  localparam int PTR0   = 4;
  localparam int PTR1   = 8;

  logic [BW-1:0] cmd_mem [DEPTH_P];
  logic [DW-1:0] rx_mem  [DEPTH_P];
  logic [DW-1:0] rx_q;
  logic [1:0]    rd_kind_q;
  logic          wr_cmd, wr_ctrl, wr_stat;

  assign wr_cmd  = wr_en && (wr_addr[ADDR_W-1:IDX_W] == 2'd0);
  assign wr_ctrl = wr_en && (wr_addr == {2'd2, IDX_W'(0)});
  assign wr_stat = wr_en && (wr_addr == {2'd2, IDX_W'(1)});

  always_ff @(posedge clk) begin
    if (wr_cmd) cmd_mem[wr_addr[IDX_W-1:0]] <= wr_data;
    cmd_q <= cmd_mem[cmd_raddr];
  end

  always_ff @(posedge clk) begin
    if (rx_we) rx_mem[rx_waddr] <= rx_wdata;
    rx_q <= rx_mem[rd_addr[IDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      wrap      <= 1'b0;
      start_ptr <= '0;
      end_ptr   <= '0;
      done_flag <= 1'b0;
      rd_kind_q <= 2'd0;
    end else begin
      if (wr_ctrl) begin
        run       <= wr_data[0];
        wrap      <= wr_data[1];
        start_ptr <= wr_data[PTR0 +: IDX_W];
        end_ptr   <= wr_data[PTR1 +: IDX_W];
      end
      if (finish) run <= 1'b0;
      if (wr_stat && wr_data[0]) done_flag <= 1'b0;
      if (finish) done_flag <= 1'b1;
      case (rd_addr[ADDR_W-1:IDX_W])
        2'd1:    rd_kind_q <= 2'd1;
        2'd2:    rd_kind_q <= (rd_addr[IDX_W-1:0] == IDX_W'(0)) ? 2'd2 :
                              (rd_addr[IDX_W-1:0] == IDX_W'(1)) ? 2'd3 : 2'd0;
        default: rd_kind_q <= 2'd0;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_kind_q)
      2'd1: rd_data[DW-1:0] = rx_q;
      2'd2: begin
        rd_data[0]             = run;
        rd_data[1]             = wrap;
        rd_data[PTR0 +: IDX_W] = start_ptr;
        rd_data[PTR1 +: IDX_W] = end_ptr;
      end
      2'd3: rd_data[0] = done_flag;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/spiq_ctrl.sv
module spiq_ctrl import spiq_pkg::*; #(
  parameter int DW      = DATA_W,
  parameter int NCS     = NUM_CS,
  parameter int DEPTH_P = DEPTH,
  parameter int DLY_P   = DLY_W,
  parameter int DIV     = HALF_DIV,
  parameter int BW      = BUS_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [$clog2(DEPTH_P)+1:0] wr_addr,
  input  logic [BW-1:0]              wr_data,
  input  logic [$clog2(DEPTH_P)+1:0] rd_addr,
  output logic [BW-1:0]              rd_data,
  output logic                       sclk,
  output logic                       mosi,
  input  logic                       miso,
  output logic [NCS-1:0]             cs_n
);
  localparam int IDX_W   = $clog2(DEPTH_P);
  localparam int LEN_W   = $clog2(DW);
  localparam int CS_W    = $clog2(NCS);
  localparam int LEN_LSB = DW;
  localparam int CS_LSB  = LEN_LSB + LEN_W;
  localparam int DLY_LSB = CS_LSB + CS_W;

  logic [BW-1:0]    cmd_q;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] start_ptr, end_ptr;
  logic             run, wrap, done_flag, finish;
  logic             eng_start, eng_done, rx_we;
  logic [DW-1:0]    eng_rx;

  spiq_regs #(.DW(DW), .DEPTH_P(DEPTH_P), .BW(BW)) regs_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .cmd_raddr(idx), .cmd_q(cmd_q),
    .rx_we(rx_we), .rx_waddr(idx), .rx_wdata(eng_rx),
    .finish(finish), .run(run), .wrap(wrap),
    .start_ptr(start_ptr), .end_ptr(end_ptr), .done_flag(done_flag)
  );

  spiq_seq #(.DEPTH_P(DEPTH_P), .DLY_P(DLY_P)) seq_i (
    .clk(clk), .rst(rst), .run(run), .wrap(wrap),
    .start_ptr(start_ptr), .end_ptr(end_ptr),
    .dly(cmd_q[DLY_LSB +: DLY_P]), .eng_done(eng_done),
    .idx(idx), .eng_start(eng_start), .rx_we(rx_we), .finish(finish)
  );

  spiq_engine #(.DW(DW), .NCS(NCS), .DIV(DIV)) eng_i (
    .clk(clk), .rst(rst), .start(eng_start),
    .tx(cmd_q[DW-1:0]), .len_m1(cmd_q[LEN_LSB +: LEN_W]),
    .cs_sel(cmd_q[CS_LSB +: CS_W]), .miso(miso),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .done(eng_done), .rx(eng_rx)
  );
endmodule

// File: rtl/spiq_ctrl_chk.sv
module spiq_ctrl_chk #(
  parameter int NCS    = 4,
  parameter int ADDR_W = 6,
  parameter int BW     = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [NCS-1:0]    cs_n,
  input logic              sclk,
  input logic              done_flag,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BW-1:0]     wr_data
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(33);

  p_cs_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));

  p_cs_switch_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(cs_n) |-> (&$past(cs_n) || &cs_n));

  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (&cs_n) |-> !sclk);

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (done_flag && !(wr_en && wr_addr == STAT_A && wr_data[0])) |=> done_flag);

  p_done_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> (&cs_n));
endmodule

bind spiq_ctrl spiq_ctrl_chk #(.NCS(NCS), .ADDR_W($clog2(DEPTH_P) + 2), .BW(BW)) chk_i (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .done_flag(done_flag),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/spiq_ctrl_tb_top.sv
module spiq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NTAB = 6;
  // fields per row: slot, tx, bit count, chip select, pause
  localparam logic [47:0] TAB [NTAB] = '{
    {8'd2, 16'hA5F0, 8'd16, 8'd0, 8'd0},
    {8'd3, 16'h0013, 8'd5,  8'd1, 8'd3},
    {8'd4, 16'h00C7, 8'd8,  8'd2, 8'd0},
    {8'd5, 16'h0001, 8'd1,  8'd3, 8'd7},
    {8'd6, 16'h0ABC, 8'd12, 8'd1, 8'd1},
    {8'd7, 16'h7FFE, 8'd16, 8'd2, 8'd2}
  };
  localparam logic [47:0] WTAB [3] = '{
    {8'd14, 16'h1234, 8'd16, 8'd3, 8'd0},
    {8'd15, 16'h0055, 8'd8,  8'd0, 8'd1},
    {8'd0,  16'h0006, 8'd3,  8'd1, 8'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        sclk, mosi;
  logic        miso = 1'b0;
  logic [3:0]  cs_n;

  int checks = 0;
  int errors = 0;
  bit sim_done = 1'b0;

  spiq_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // peripheral model and transfer log
  int          n_x;
  int          gap_cnt, bit_cnt, cur_cs;
  logic [31:0] mo_word;
  logic [15:0] resp_sh;
  bit          prev_act, prev_sclk;
  int          log_cs [64];
  int          log_bits [64];
  int          log_gap [64];
  logic [31:0] log_mo [64];
  logic [15:0] log_resp [64];

  function automatic logic [15:0] resp_of(input int k);
    return 16'hC3A5 + 16'(k * 16'h0F1D);
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      n_x = 0; gap_cnt = 0; prev_act = 0; prev_sclk = 0; miso = 1'b0;
    end else begin
      bit act;
      act = ~&cs_n;
      if (act && !prev_act) begin
        cur_cs = 0;
        for (int i = 0; i < 4; i++) if (!cs_n[i]) cur_cs = i;
        resp_sh = resp_of(n_x);
        if (n_x < 64) begin
          log_gap[n_x] = gap_cnt; log_cs[n_x] = cur_cs; log_resp[n_x] = resp_sh;
        end
        miso = resp_sh[15]; bit_cnt = 0; mo_word = '0;
      end
      if (act && sclk && !prev_sclk) begin
        mo_word = {mo_word[30:0], mosi}; bit_cnt++;
      end
      if (act && !sclk && prev_sclk) begin
        resp_sh = resp_sh << 1; miso = resp_sh[15];
      end
      if (!act && prev_act) begin
        if (n_x < 64) begin log_bits[n_x] = bit_cnt; log_mo[n_x] = mo_word; end
        n_x++; gap_cnt = 0;
      end
      if (!act) gap_cnt++;
      prev_act = act; prev_sclk = sclk;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic cpu_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic cpu_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  function automatic logic [31:0] cmd_word(input logic [47:0] row);
    return (32'(row[7:0]) << 22) | (32'(row[15:8]) << 20) |
           (32'(row[23:16] - 8'd1) << 16) | 32'(row[39:24]);
  endfunction

  function automatic logic [31:0] mask_of(input int len);
    return (32'd1 << len) - 32'd1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!sim_done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    int base, nclr, len;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk(cs_n == 4'hF, "R1 cs_n", 32'(cs_n), 32'hF);
    chk(sclk == 1'b0, "R1 sclk", 32'(sclk), 0);
    cpu_rd(6'd33, rv); chk(rv == 0, "R1 status", rv, 0);
    cpu_rd(6'd32, rv); chk(rv == 0, "R1 control", rv, 0);

    // one-shot run over the table
    for (int i = 0; i < NTAB; i++) cpu_wr(6'(TAB[i][47:40]), cmd_word(TAB[i]));
    cpu_wr(6'd32, (32'd7 << 8) | (32'd2 << 4) | 32'd1);
    for (int t = 0; t < 4000; t++) begin
      cpu_rd(6'd33, rv);
      if (rv[0]) break;
    end
    chk(rv[0] == 1'b1, "R8 done set", rv, 1);
    cpu_rd(6'd32, rv); chk(rv[0] == 1'b0, "R8 run cleared", rv, 0);
    chk(n_x == NTAB, "R6 transfer count", 32'(n_x), NTAB);
    for (int i = 0; i < NTAB; i++) begin
      len = int'(TAB[i][23:16]);
      chk(log_cs[i] == int'(TAB[i][15:8]), "R4 chip select", 32'(log_cs[i]), 32'(TAB[i][15:8]));
      chk(log_bits[i] == len, "R2 bit count", 32'(log_bits[i]), 32'(len));
      chk(log_mo[i] == (32'(TAB[i][39:24]) & mask_of(len)), "R2 R3 mosi word",
          log_mo[i], 32'(TAB[i][39:24]) & mask_of(len));
      if (i > 0)
        chk(log_gap[i] == int'(TAB[i-1][7:0]) + 4, "R7 pause", 32'(log_gap[i]), 32'(TAB[i-1][7:0]) + 4);
      cpu_rd(6'(16 + TAB[i][47:40]), rv);
      chk(rv == 32'(log_resp[i] >> (16 - len)), "R5 receive slot", rv, 32'(log_resp[i] >> (16 - len)));
    end
    repeat (50) @(negedge clk);
    cpu_rd(6'd33, rv); chk(rv[0] == 1'b1, "R8 flag sticky", rv, 1);
    cpu_wr(6'd33, 32'd1);
    cpu_rd(6'd33, rv); chk(rv[0] == 1'b0, "R8 flag cleared", rv, 0);

    // continuous run across slot 15 -> 0, stopped mid-word
    base = n_x;
    for (int i = 0; i < 3; i++) cpu_wr(6'(WTAB[i][47:40]), cmd_word(WTAB[i]));
    cpu_wr(6'd32, (32'd0 << 8) | (32'd14 << 4) | 32'd3);
    for (int t = 0; t < 20000; t++) begin
      @(negedge clk);
      if (n_x >= base + 7 && ~&cs_n && !sclk) break;
    end
    nclr = n_x;
    cpu_wr(6'd32, (32'd0 << 8) | (32'd14 << 4) | 32'd2);
    repeat (2000) @(negedge clk);
    chk(n_x == nclr + 1, "R10 stops after current word", 32'(n_x), 32'(nclr + 1));
    for (int k = 0; k < n_x - base; k++) begin
      len = int'(WTAB[k % 3][23:16]);
      chk(log_cs[base+k] == int'(WTAB[k % 3][15:8]), "R9 R11 wrap order cs",
          32'(log_cs[base+k]), 32'(WTAB[k % 3][15:8]));
      chk(log_mo[base+k] == (32'(WTAB[k % 3][39:24]) & mask_of(len)), "R9 R11 wrap order data",
          log_mo[base+k], 32'(WTAB[k % 3][39:24]) & mask_of(len));
      chk(log_bits[base+k] == len, "R10 full word", 32'(log_bits[base+k]), 32'(len));
      if (k > 0)
        chk(log_gap[base+k] == int'(WTAB[(k-1) % 3][7:0]) + 4, "R9 R7 wrap pause",
            32'(log_gap[base+k]), 32'(WTAB[(k-1) % 3][7:0]) + 4);
    end
    cpu_rd(6'd33, rv); chk(rv[0] == 1'b0, "R10 no completion flag", rv, 0);
    chk(cs_n == 4'hF && sclk == 1'b0, "R3 R10 bus idle", {27'd0, sclk, cs_n}, 32'hF);

    sim_done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule